// File: doc/BRIEF.md
# Fractional-Ratio Memory Clock Generator

The block derives a slower memory-side clock from a fast core clock. A 3-bit ratio code selects the division. Besides the usual integer ratios there are divide-by-1.5 and divide-by-2.5. These need an output that changes on both edges of the core clock, so the generator keeps one register set on the rising edge and one on the falling edge, and selects between them with the core clock level.

The block has three outputs from the divider. Two copies drive the memory devices and can be gated. The third is a synchronization clock that never stops, so an external tracking loop stays locked while the memory clocks are parked. When the clock-stop enable is set, the memory clocks are parked during sleep and during nap. A snoop request during nap lets them run again for its duration.

A new ratio code and a new gate decision take effect only at the end of an output period, when the output is low. Because of this the block produces no runt pulse. Three status outputs report:
- a code that stops the clock and turns off the tracking loop;
- a reserved code;
- a ratio whose output would be slower than the supplied bus-clock ratio.

Top module: `ratio_clk_gen`

## Requirements
- R1: Integer ratios. Code 3'b001 gives a period of 2 core half-cycles with 1 half high (the output follows the core clock). Code 3'b100 gives a period of 4 halves with 2 high. Code 3'b110 gives a period of 6 halves with 3 high.
- R2: Half-integer ratios. Code 3'b010 gives a period of 3 core half-cycles with 1 half high. Code 3'b101 gives a period of 5 halves with 2 high. Both need output changes on both core edges.
- R3: Code 3'b000 holds all three clock outputs low and drives `dll_off` high. `dll_off` is high in reset.
- R4: Codes 3'b011 and 3'b111 are reserved. They hold all three clock outputs low, drive `code_err` high and keep `dll_off` low. `code_err` and `dll_off` are never high together.
- R5: `bus_ratio_x2` gives twice the core-to-bus frequency ratio. `ratio_err` is high exactly when a running code's period in core half-cycles (2, 3, 4, 5 or 6) is greater than `bus_ratio_x2`. `ratio_err` is low whenever the clock is stopped.
- R6: With `stop_en` high, and either `sleep` high or (`nap` high and `snoop` low), both memory clocks stay low while `sync_clk` keeps toggling at the selected ratio.
- R7: The memory clocks run and equal `sync_clk` when `stop_en` is low, or during nap with `snoop` high. In that state `ram_clk_a` equals `ram_clk_b`, and neither is ever high while `sync_clk` is low.
- R8: Ratio changes apply only at a period boundary. Every high pulse and every low gap has the full length of either the old ratio or the new one.
- R9: In reset, all clock outputs and both error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Fast core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_code | input | 3 | Division ratio select |
| bus_ratio_x2 | input | BUS_W | Twice the core-to-bus ratio |
| nap | input | 1 | Nap low-power state |
| sleep | input | 1 | Sleep low-power state |
| snoop | input | 1 | Snoop request while napping |
| stop_en | input | 1 | Allow memory clock gating in low-power states |
| ram_clk_a | output | 1 | Gated memory clock, copy A |
| ram_clk_b | output | 1 | Gated memory clock, copy B |
| sync_clk | output | 1 | Ungated synchronization clock |
| dll_off | output | 1 | Clock stopped and tracking loop disabled |
| code_err | output | 1 | Reserved ratio code active |
| ratio_err | output | 1 | Output slower than bus clock |

## Verification
The bench uses the default BUS_W of 4, so `bus_ratio_x2` covers every period length the divider can produce. It sweeps all eight ratio codes and measures high and low run lengths at every core half-cycle. It also crosses each running code with bus ratios on both sides of the threshold. It toggles between divide-by-1.5 and divide-by-3 at irregular times to expose runt pulses at ratio changes. Finally it walks through the combinations of low-power states, snoop and stop enable.

// File: rtl/ratio_clk_gen.sv
module ratio_clk_gen #(
  parameter int BUS_W = 4
) (
  input  logic             clk_core,
  input  logic             rst_n,
  input  logic [2:0]       ratio_code,
  input  logic [BUS_W-1:0] bus_ratio_x2,
  input  logic             nap,
  input  logic             sleep,
  input  logic             snoop,
  input  logic             stop_en,
  output logic             ram_clk_a,
  output logic             ram_clk_b,
  output logic             sync_clk,
  output logic             dll_off,
  output logic             code_err,
  output logic             ratio_err
);

  function automatic logic [2:0] halves(input logic [2:0] c);
    case (c)
      3'b001:  return 3'd2;
      3'b010:  return 3'd3;
      3'b100:  return 3'd4;
      3'b101:  return 3'd5;
      3'b110:  return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic phase_hi(input logic [3:0] k, input logic [2:0] h);
    logic [3:0] hw, m;
    hw = {1'b0, h};
    m  = (k >= hw) ? k - hw : k;
    return (h != 3'd0) && (m < {2'b00, h[2:1]});
  endfunction

  logic [2:0] req_q, act_q, cnt_q;
  logic       ramok_q, ram_run_q;
  logic       pre_s_q, pre_r_q, hi_s_q, hi_r_q, lo_s_q, lo_r_q;

  logic [2:0] h_act, act_nx, h_nx, cnt_nx;
  logic       load, wrap2, want_ok, ramrun_nx, pre_s, pre_r, lo_s_nx;

  assign h_act     = halves(act_q);
  assign load      = (h_act == 3'd0) || (cnt_q == h_act - 3'd1);
  assign act_nx    = load ? req_q : act_q;
  assign ramrun_nx = load ? ramok_q : ram_run_q;
  assign h_nx      = halves(act_nx);
  assign cnt_nx    = load ? 3'd0 : cnt_q + 3'd1;
  assign wrap2     = (h_nx == 3'd0) || (cnt_nx == h_nx - 3'd1);
  assign want_ok   = !(stop_en && (sleep || (nap && !snoop)));
  assign pre_s     = wrap2 ? (halves(ratio_code) != 3'd0)
                           : phase_hi({cnt_nx, 1'b0} + 4'd2, h_nx);
  assign pre_r     = pre_s && (wrap2 ? want_ok : ramrun_nx);
  assign lo_s_nx   = phase_hi({cnt_nx, 1'b1}, h_nx);

  always_ff @(posedge clk_core or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 3'b000;
      act_q     <= 3'b000;
      cnt_q     <= 3'd0;
      ramok_q   <= 1'b0;
      ram_run_q <= 1'b0;
      pre_s_q   <= 1'b0;
      pre_r_q   <= 1'b0;
      lo_s_q    <= 1'b0;
      lo_r_q    <= 1'b0;
    end else begin
      req_q     <= ratio_code;
      ramok_q   <= want_ok;
      act_q     <= act_nx;
      ram_run_q <= ramrun_nx;
      cnt_q     <= cnt_nx;
      pre_s_q   <= pre_s;
      pre_r_q   <= pre_r;
      lo_s_q    <= lo_s_nx;
      lo_r_q    <= lo_s_nx && ramrun_nx;
    end
  end

  always_ff @(negedge clk_core or negedge rst_n) begin
    if (!rst_n) begin
      hi_s_q <= 1'b0;
      hi_r_q <= 1'b0;
    end else begin
      hi_s_q <= pre_s_q;
      hi_r_q <= pre_r_q;
    end
  end

  assign sync_clk  = clk_core ? hi_s_q : lo_s_q;
  assign ram_clk_a = clk_core ? hi_r_q : lo_r_q;
  assign ram_clk_b = clk_core ? hi_r_q : lo_r_q;
  assign dll_off   = (act_q == 3'b000);
  assign code_err  = (act_q == 3'b011) || (act_q == 3'b111);
  assign ratio_err = (h_act != 3'd0) && (int'(h_act) > int'(bus_ratio_x2));

endmodule

// File: rtl/ratio_clk_gen_chk.sv
module ratio_clk_gen_chk (
  input logic clk_core,
  input logic rst_n,
  input logic ram_clk_a,
  input logic ram_clk_b,
  input logic sync_clk,
  input logic dll_off,
  input logic code_err,
  input logic ratio_err
);

  // R4
  err_excl_chk: assert property (@(posedge clk_core) disable iff (!rst_n)
    !(code_err && dll_off));

  // R5
  ratio_running_chk: assert property (@(posedge clk_core) disable iff (!rst_n)
    ratio_err |-> (!dll_off && !code_err));

  // R7
  ram_copies_chk: assert property (@(posedge clk_core) disable iff (!rst_n)
    ram_clk_a == ram_clk_b);

  // R7
  ram_in_sync_lo_chk: assert property (@(posedge clk_core) disable iff (!rst_n)
    ram_clk_a |-> sync_clk);

  // R7
  ram_in_sync_hi_chk: assert property (@(negedge clk_core) disable iff (!rst_n)
    ram_clk_b |-> sync_clk);

  // R3
  stopped_quiet_chk: assert property (@(negedge clk_core) disable iff (!rst_n)
    (dll_off && $stable(dll_off)) |-> !sync_clk);

endmodule

bind ratio_clk_gen ratio_clk_gen_chk chk_i (
  .clk_core (clk_core),
  .rst_n    (rst_n),
  .ram_clk_a(ram_clk_a),
  .ram_clk_b(ram_clk_b),
  .sync_clk (sync_clk),
  .dll_off  (dll_off),
  .code_err (code_err),
  .ratio_err(ratio_err)
);

// File: tb/ratio_clk_gen_tb_top.sv
module ratio_clk_gen_tb_top;
  logic       clk_core = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ratio_code = 3'b000;
  logic [3:0] bus_ratio_x2 = 4'd15;
  logic       nap = 1'b0, sleep = 1'b0, snoop = 1'b0, stop_en = 1'b0;
  logic       ram_clk_a, ram_clk_b, sync_clk, dll_off, code_err, ratio_err;
  int         n_chk = 0, n_bad = 0;

  always #2 clk_core = ~clk_core;

  ratio_clk_gen #(.BUS_W(4)) dut_i (
    .clk_core(clk_core), .rst_n(rst_n), .ratio_code(ratio_code),
    .bus_ratio_x2(bus_ratio_x2), .nap(nap), .sleep(sleep), .snoop(snoop),
    .stop_en(stop_en), .ram_clk_a(ram_clk_a), .ram_clk_b(ram_clk_b),
    .sync_clk(sync_clk), .dll_off(dll_off), .code_err(code_err),
    .ratio_err(ratio_err));

  function automatic int period_of(input logic [2:0] c);
    case (c)
      3'b001: return 2;
      3'b010: return 3;
      3'b100: return 4;
      3'b101: return 5;
      3'b110: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic samp();
    @(posedge clk_core or negedge clk_core);
    #1;
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) samp();
  endtask

  task automatic measure(output int hi, output int lo);
    logic p;
    int g;
    hi = 0; lo = 0; g = 0;
    samp(); p = sync_clk;
    while (!(!p && sync_clk) && g < 80) begin p = sync_clk; samp(); g++; end
    if (g >= 80) return;
    while (sync_clk && hi < 40) begin hi++; samp(); end
    while (!sync_clk && lo < 40) begin lo++; samp(); end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hi, lo, bad, tog;
    logic p;
    #5;
    // R9 and R3 in reset
    check(!sync_clk && !ram_clk_a && !ram_clk_b, "R9 clocks", sync_clk, 0);
    check(!code_err && !ratio_err, "R9 errors", code_err + ratio_err, 0);
    check(dll_off, "R3 dll_off in reset", dll_off, 1);
    rst_n = 1'b1;
    skip(6);

    for (int c = 0; c < 8; c++) begin
      int h;
      ratio_code = 3'(c);
      h = period_of(3'(c));
      skip(30);
      check(dll_off == (c == 0), c == 0 ? "R3 dll_off" : "R4 dll_off", dll_off, c == 0);
      check(code_err == (c == 3 || c == 7), "R4 code_err", code_err, (c == 3 || c == 7));
      if (h == 0) begin
        bad = 0;
        for (int i = 0; i < 24; i++) begin
          samp();
          if (sync_clk || ram_clk_a || ram_clk_b) bad++;
        end
        check(bad == 0, c == 0 ? "R3 stopped low" : "R4 stopped low", bad, 0);
      end else begin
        measure(hi, lo);
        check(hi == h / 2, (h % 2) ? "R2 high length" : "R1 high length", hi, h / 2);
        check(lo == h - h / 2, (h % 2) ? "R2 low length" : "R1 low length", lo, h - h / 2);
        bad = 0;
        for (int i = 0; i < 4 * h; i++) begin
          samp();
          if (ram_clk_a != sync_clk || ram_clk_b != sync_clk) bad++;
        end
        check(bad == 0, "R7 ram follows sync", bad, 0);
        for (int b = 1; b < 9; b++) begin
          bus_ratio_x2 = 4'(b);
          skip(4);
          check(ratio_err == (h > b), "R5 ratio_err", ratio_err, h > b);
        end
        bus_ratio_x2 = 4'd15;
      end
    end

    // R8 irregular changes between /1.5 and /3
    bad = 0;
    ratio_code = 3'b010;
    skip(20);
    samp(); p = sync_clk; hi = 0; lo = 0;
    for (int i = 0; i < 400; i++) begin
      if (i % 23 == 7) ratio_code = (ratio_code == 3'b010) ? 3'b110 : 3'b010;
      samp();
      if (sync_clk) begin
        if (!p && lo != 0 && lo != 2 && lo != 3 && i > 0) bad++;
        if (!p) hi = 0;
        hi++;
      end else begin
        if (p && hi != 1 && hi != 3) bad++;
        if (p) lo = 0;
        lo++;
      end
      p = sync_clk;
    end
    check(bad == 0, "R8 no runt pulse", bad, 0);

    // R6 / R7 gating
    ratio_code = 3'b100;
    for (int m = 0; m < 6; m++) begin
      bit gated;
      stop_en = (m != 5);
      nap   = (m == 0 || m == 2 || m == 5);
      sleep = (m == 1 || m == 3 || m == 5);
      snoop = (m == 2 || m == 3);
      if (m == 4) begin nap = 1'b0; sleep = 1'b0; end
      gated = stop_en && (sleep || (nap && !snoop));
      skip(24);
      bad = 0; tog = 0;
      samp(); p = sync_clk;
      for (int i = 0; i < 32; i++) begin
        samp();
        if (sync_clk != p) tog++;
        p = sync_clk;
        if (gated ? (ram_clk_a || ram_clk_b)
                  : (ram_clk_a != sync_clk || ram_clk_b != sync_clk)) bad++;
      end
      check(bad == 0, gated ? "R6 ram parked" : "R7 ram running", bad, 0);
      check(tog == 16, "R6 sync keeps toggling", tog, 16);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule